// File: doc/BRIEF.md
# Queue FIFO Request Controller

This block collects the per-queue status flags of a multi-queue converter front end and turns them into interrupt lines and DMA requests. Every queue owns a command FIFO and a result FIFO. The queue logic sends single-cycle event pulses, and each FIFO reports whether it is empty or full. The block holds eight flags per queue. It gates each flag with an enable bit and drives one registered request line per flag.

The result drain flag and the command fill flag can each be routed by a select bit to an interrupt line or to a DMA request. In DMA mode the flag clears itself when its FIFO reaches the state that ends the transfer, and software writes to it are ignored. The overflow, underflow and trigger-overrun requests of all queues are also merged into one error interrupt.

Software uses a small register port with a write strobe. The address is `{queue[2:0], kind[1:0]}`. Kind 0 holds the flags and is write-one-to-clear. Kind 1 holds the enables. Kind 2 holds the selects, with bit 0 for drain to DMA and bit 1 for fill to DMA. Reads are combinational.

Top module: `fifo_req_ctrl`

## Requirements
- R1: Reset sets all flags, enables, selects and request outputs to 0. Every register reads back 0.
- R2: A pulse on event bit b of queue q sets flag b of that queue. The flag bit positions are: 0 non-coherency, 1 result overflow, 2 command underflow, 3 result drain, 4 command fill, 5 end of queue, 6 pause, 7 trigger overrun. Event bits 3 and 4 are ignored.
- R3: Interrupt line q*8+b is 1 in the cycle after flag b and enable b of queue q are both 1. For bits 3 and 4 the matching select bit must also be 0.
- R4: Writing 1 to a flag bit through kind 0 clears that flag, except a DMA-mode drain or fill flag. Writing 0 leaves the flag unchanged.
- R5: If a set event and a software clear hit the same flag in the same cycle, the flag stays 1.
- R6: The drain flag sets while the result FIFO is not empty. With select bit 0 at 1 and the drain enable at 1, it drives the drain DMA request and not the drain interrupt.
- R7: The fill flag sets while the command FIFO is not full. With select bit 1 at 1 and the fill enable at 1, it drives the fill DMA request and not the fill interrupt.
- R8: In DMA mode the drain flag clears when the result FIFO is empty, and a software write of 1 to it has no effect.
- R9: In DMA mode the fill flag clears when the command FIFO is full, and a software write of 1 to it has no effect.
- R10: The error interrupt is the OR, across all queues, of the enabled overflow, underflow and trigger-overrun requests. It appears in the same cycle as those individual lines.
- R11: Kind 1 and kind 2 writes load the enable and select registers of the addressed queue only. Reads return the flags, the enables, or the selects zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | {queue, kind} register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr |
| evtSet | input | NUM_Q*8 | Event pulses, queue q at bits q*8+7..q*8 |
| rfifoEmpty | input | NUM_Q | Result FIFO empty, one per queue |
| cfifoFull | input | NUM_Q | Command FIFO full, one per queue |
| irqOut | output | NUM_Q*8 | Per-flag interrupt lines |
| dmaDrain | output | NUM_Q | Drain DMA request per queue |
| dmaFill | output | NUM_Q | Fill DMA request per queue |
| errIrq | output | 1 | Combined error interrupt |

## Verification
The assertions assume that software addresses only queues that exist and that event pulses are true single-cycle strobes. The FIFO empty and full inputs are treated as free-running levels with no required relation to the events. The stimulus keeps the queue field below the queue count. It toggles empty and full at random and independently, and it mixes writes of every kind with sparse events, so that set-and-clear collisions and select changes under a live FIFO both occur.

// File: rtl/fifo_req_pkg.sv
package fifo_req_pkg;
  localparam int FLAG_N = 8;
  localparam int QIDX_W = 3;
  localparam int B_NONCOH = 0;
  localparam int B_ROVF   = 1;
  localparam int B_CUNF   = 2;
  localparam int B_DRAIN  = 3;
  localparam int B_FILL   = 4;
  localparam int B_EOQ    = 5;
  localparam int B_PAUSE  = 6;
  localparam int B_TOVR   = 7;

  typedef enum logic [1:0] {
    RK_FLAGS  = 2'd0,
    RK_ENABLE = 2'd1,
    RK_SELECT = 2'd2,
    RK_NONE   = 2'd3
  } regKind_t;

  typedef struct packed {
    logic              clrFlags;
    logic              ldEnable;
    logic              ldSelect;
    logic [QIDX_W-1:0] queue;
    logic [FLAG_N-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/fifo_req_regif.sv
module fifo_req_regif
  import fifo_req_pkg::*;
#(
  parameter int NUM_Q = 6
) (
  input  logic                           regWe,
  input  logic [QIDX_W+1:0]              regAddr,
  input  logic [FLAG_N-1:0]              regWdata,
  input  logic [NUM_Q-1:0][FLAG_N-1:0]   flagsQ,
  input  logic [NUM_Q-1:0][FLAG_N-1:0]   enQ,
  input  logic [NUM_Q-1:0][1:0]          selQ,
  output regStrobe_t                     strobe,
  output logic [FLAG_N-1:0]              regRdata
);
  regKind_t          kind;
  logic [QIDX_W-1:0] qIdx;
  logic              qValid;

  assign kind   = regKind_t'(regAddr[1:0]);
  assign qIdx   = regAddr[QIDX_W+1:2];
  assign qValid = ({1'b0, qIdx} < (QIDX_W+1)'(NUM_Q));

  always_comb begin
    strobe       = '0;
    strobe.queue = qIdx;
    strobe.data  = regWdata;
    if (regWe && qValid) begin
      case (kind)
        RK_FLAGS:  strobe.clrFlags = 1'b1;
        RK_ENABLE: strobe.ldEnable = 1'b1;
        RK_SELECT: strobe.ldSelect = 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    if (qValid) begin
      case (kind)
        RK_FLAGS:  regRdata = flagsQ[qIdx];
        RK_ENABLE: regRdata = enQ[qIdx];
        RK_SELECT: regRdata = {{(FLAG_N-2){1'b0}}, selQ[qIdx]};
        default:   regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fifo_req_flags.sv
module fifo_req_flags
  import fifo_req_pkg::*;
#(
  parameter int NUM_Q = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  regStrobe_t                     strobe,
  input  logic [NUM_Q-1:0][FLAG_N-1:0]   evtSet,
  input  logic [NUM_Q-1:0]               rfifoEmpty,
  input  logic [NUM_Q-1:0]               cfifoFull,
  output logic [NUM_Q-1:0][FLAG_N-1:0]   flagsQ,
  output logic [NUM_Q-1:0][FLAG_N-1:0]   enQ,
  output logic [NUM_Q-1:0][1:0]          selQ,
  output logic [NUM_Q-1:0][FLAG_N-1:0]   irqQ,
  output logic [NUM_Q-1:0]               dmaDrain,
  output logic [NUM_Q-1:0]               dmaFill,
  output logic                           errIrq
);
  logic [NUM_Q-1:0][FLAG_N-1:0] reqQ;
  logic                         errAny;
  logic                         errOut;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    logic              hit;
    logic [FLAG_N-1:0] setV;
    logic [FLAG_N-1:0] clrV;

    assign hit = (strobe.queue == QIDX_W'(q));

    always_comb begin
      setV          = evtSet[q];
      setV[B_DRAIN] = !rfifoEmpty[q];
      setV[B_FILL]  = !cfifoFull[q];
      clrV = (strobe.clrFlags && hit) ? strobe.data : '0;
      if (selQ[q][0]) clrV[B_DRAIN] = rfifoEmpty[q];
      if (selQ[q][1]) clrV[B_FILL]  = cfifoFull[q];
    end

    always_comb begin
      reqQ[q]          = flagsQ[q] & enQ[q];
      reqQ[q][B_DRAIN] = flagsQ[q][B_DRAIN] & enQ[q][B_DRAIN] & !selQ[q][0];
      reqQ[q][B_FILL]  = flagsQ[q][B_FILL]  & enQ[q][B_FILL]  & !selQ[q][1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flagsQ[q]   <= '0;
        enQ[q]      <= '0;
        selQ[q]     <= '0;
        irqQ[q]     <= '0;
        dmaDrain[q] <= 1'b0;
        dmaFill[q]  <= 1'b0;
      end else begin
        flagsQ[q]   <= setV | (flagsQ[q] & ~clrV);
        if (strobe.ldEnable && hit) enQ[q]  <= strobe.data;
        if (strobe.ldSelect && hit) selQ[q] <= strobe.data[1:0];
        irqQ[q]     <= reqQ[q];
        dmaDrain[q] <= flagsQ[q][B_DRAIN] & enQ[q][B_DRAIN] & selQ[q][0];
        dmaFill[q]  <= flagsQ[q][B_FILL]  & enQ[q][B_FILL]  & selQ[q][1];
      end
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      evtSet[q][B_EOQ] |=> flagsQ[q][B_EOQ]);
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
      (strobe.clrFlags && hit && strobe.data[B_PAUSE] && !evtSet[q][B_PAUSE])
        |=> !flagsQ[q][B_PAUSE]);
    p_irq_lat_r3: assert property (@(posedge clk) disable iff (rst)
      (flagsQ[q][B_NONCOH] && enQ[q][B_NONCOH]) |=> irqQ[q][B_NONCOH]);
    p_dma_route_r6: assert property (@(posedge clk) disable iff (rst)
      dmaDrain[q] |-> !irqQ[q][B_DRAIN]);
    p_drain_auto_r8: assert property (@(posedge clk) disable iff (rst)
      (selQ[q][0] && rfifoEmpty[q]) |=> !flagsQ[q][B_DRAIN]);
    p_fill_auto_r9: assert property (@(posedge clk) disable iff (rst)
      (selQ[q][1] && cfifoFull[q]) |=> !flagsQ[q][B_FILL]);
  end

  always_comb begin
    errAny = 1'b0;
    errOut = 1'b0;
    for (int q = 0; q < NUM_Q; q++) begin
      errAny = errAny | reqQ[q][B_ROVF] | reqQ[q][B_CUNF] | reqQ[q][B_TOVR];
      errOut = errOut | irqQ[q][B_ROVF] | irqQ[q][B_CUNF] | irqQ[q][B_TOVR];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) errIrq <= 1'b0;
    else     errIrq <= errAny;
  end

  p_err_merge_r10: assert property (@(posedge clk) disable iff (rst)
    errIrq == errOut);
endmodule

// File: rtl/fifo_req_ctrl.sv
module fifo_req_ctrl
  import fifo_req_pkg::*;
#(
  parameter int NUM_Q = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    regWe,
  input  logic [QIDX_W+1:0]       regAddr,
  input  logic [FLAG_N-1:0]       regWdata,
  output logic [FLAG_N-1:0]       regRdata,
  input  logic [NUM_Q*FLAG_N-1:0] evtSet,
  input  logic [NUM_Q-1:0]        rfifoEmpty,
  input  logic [NUM_Q-1:0]        cfifoFull,
  output logic [NUM_Q*FLAG_N-1:0] irqOut,
  output logic [NUM_Q-1:0]        dmaDrain,
  output logic [NUM_Q-1:0]        dmaFill,
  output logic                    errIrq
);
  regStrobe_t                   strobe;
  logic [NUM_Q-1:0][FLAG_N-1:0] flagsQ;
  logic [NUM_Q-1:0][FLAG_N-1:0] enQ;
  logic [NUM_Q-1:0][1:0]        selQ;
  logic [NUM_Q-1:0][FLAG_N-1:0] evtQ;
  logic [NUM_Q-1:0][FLAG_N-1:0] irqQ;

  assign evtQ   = evtSet;
  assign irqOut = irqQ;

  fifo_req_regif #(.NUM_Q(NUM_Q)) u_regif (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .flagsQ(flagsQ), .enQ(enQ), .selQ(selQ),
    .strobe(strobe), .regRdata(regRdata)
  );

  fifo_req_flags #(.NUM_Q(NUM_Q)) u_flags (
    .clk(clk), .rst(rst), .strobe(strobe), .evtSet(evtQ),
    .rfifoEmpty(rfifoEmpty), .cfifoFull(cfifoFull),
    .flagsQ(flagsQ), .enQ(enQ), .selQ(selQ), .irqQ(irqQ),
    .dmaDrain(dmaDrain), .dmaFill(dmaFill), .errIrq(errIrq)
  );
endmodule

// File: tb/sim_fifo_req_ctrl.sv
`timescale 1ns/100ps
module sim_fifo_req_ctrl;
  localparam int NQ = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          regWe = 1'b0;
  logic [4:0]    regAddr = '0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic [NQ-1:0][7:0] evt = '0;
  logic [NQ-1:0] emp = '1;
  logic [NQ-1:0] full = '1;
  logic [NQ*8-1:0] irqOut;
  logic [NQ-1:0] dmaDrain, dmaFill;
  logic          errIrq;

  logic [7:0] mFlag [NQ];
  logic [7:0] mEn   [NQ];
  logic [1:0] mSel  [NQ];
  logic [NQ*8-1:0] xIrq;
  logic [NQ-1:0] xDd, xDf;
  logic          xErr;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_req_ctrl #(.NUM_Q(NQ)) u0 (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtSet(evt),
    .rfifoEmpty(emp), .cfifoFull(full), .irqOut(irqOut),
    .dmaDrain(dmaDrain), .dmaFill(dmaFill), .errIrq(errIrq)
  );

  function automatic logic [7:0] modelRead(logic [4:0] a);
    int q = int'(a[4:2]);
    if (q >= NQ) return 8'h00;
    case (a[1:0])
      2'd0: return mFlag[q];
      2'd1: return mEn[q];
      2'd2: return {6'b0, mSel[q]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Advance one clock with the inputs already driven; model then compare.
  task automatic tick(string tag);
    logic [7:0] nF [NQ];
    logic [NQ*8-1:0] nIrq = '0;
    logic [NQ-1:0] nDd = '0, nDf = '0;
    bit nErr = 0;
    for (int q = 0; q < NQ; q++) begin
      logic [7:0] req = mFlag[q] & mEn[q];
      logic [7:0] setB = evt[q];
      logic [7:0] clrB = 8'h00;
      bit hit = (int'(regAddr[4:2]) == q) && regWe;
      if (mSel[q][0]) req[3] = 1'b0;
      if (mSel[q][1]) req[4] = 1'b0;
      nIrq[q*8 +: 8] = req;
      nDd[q] = mFlag[q][3] & mEn[q][3] & mSel[q][0];
      nDf[q] = mFlag[q][4] & mEn[q][4] & mSel[q][1];
      if (req[1] || req[2] || req[7]) nErr = 1;
      setB[3] = !emp[q];
      setB[4] = !full[q];
      if (hit && regAddr[1:0] == 2'd0) clrB = regWdata;
      if (mSel[q][0]) clrB[3] = emp[q];
      if (mSel[q][1]) clrB[4] = full[q];
      nF[q] = setB | (mFlag[q] & ~clrB);
    end
    @(posedge clk);
    @(negedge clk);
    for (int q = 0; q < NQ; q++) begin
      bit hit = (int'(regAddr[4:2]) == q) && regWe;
      if (rst) begin
        mFlag[q] = '0; mEn[q] = '0; mSel[q] = '0;
      end else begin
        mFlag[q] = nF[q];
        if (hit && regAddr[1:0] == 2'd1) mEn[q] = regWdata;
        if (hit && regAddr[1:0] == 2'd2) mSel[q] = regWdata[1:0];
      end
    end
    if (rst) begin
      xIrq = '0; xDd = '0; xDf = '0; xErr = 0;
    end else begin
      xIrq = nIrq; xDd = nDd; xDf = nDf; xErr = nErr;
    end
    check(tag, "irqOut (R3)", 64'(irqOut), 64'(xIrq));
    check(tag, "dmaDrain (R6)", 64'(dmaDrain), 64'(xDd));
    check(tag, "dmaFill (R7)", 64'(dmaFill), 64'(xDf));
    check(tag, "errIrq (R10)", 64'(errIrq), 64'(xErr));
    check(tag, "regRdata (R11)", 64'(regRdata), 64'(modelRead(regAddr)));
  endtask

  task automatic wr(string tag, int q, int kind, logic [7:0] d);
    regWe = 1'b1; regAddr = {3'(q), 2'(kind)}; regWdata = d;
    tick(tag);
    regWe = 1'b0;
  endtask

  task automatic rd(string tag, int q, int kind, logic [7:0] exp);
    regAddr = {3'(q), 2'(kind)};
    tick(tag);
    check(tag, "readback", 64'(regRdata), 64'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin mFlag[q] = '0; mEn[q] = '0; mSel[q] = '0; end
    xIrq = '0; xDd = '0; xDf = '0; xErr = 0;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) tick("R1");
    rst = 1'b0;
    for (int q = 0; q < NQ; q++)
      for (int k = 0; k < 3; k++) rd("R1", q, k, 8'h00);

    // R11: register map, writes confined to the addressed queue
    wr("R11", 2, 1, 8'hA5);
    rd("R11", 2, 1, 8'hA5);
    rd("R11", 3, 1, 8'h00);
    wr("R11", 4, 2, 8'hFF);
    rd("R11", 4, 2, 8'h03);
    wr("R11", 4, 2, 8'h00);
    wr("R11", 2, 1, 8'h00);

    // R2: events set flags, drain/fill event bits ignored
    evt[1] = 8'hFF; tick("R2"); evt = '0;
    rd("R2", 1, 0, 8'hE7);

    // R3: enables raise lines one cycle later
    wr("R3", 1, 1, 8'hFF);
    tick("R3");
    check("R3", "irq pause line", 64'(irqOut[1*8+6]), 64'(1));

    // R4: write one clears, write zero keeps
    wr("R4", 1, 0, 8'h00);
    rd("R4", 1, 0, 8'hE7);
    wr("R4", 1, 0, 8'h21);
    rd("R4", 1, 0, 8'hC6);

    // R5: set beats clear in the same cycle
    evt[1] = 8'h40; wr("R5", 1, 0, 8'h40); evt = '0;
    rd("R5", 1, 0, 8'hC6);

    // R6: drain routing
    wr("R6", 1, 0, 8'hFF);
    emp[1] = 1'b0; tick("R6"); tick("R6");
    check("R6", "drain irq", 64'(irqOut[1*8+3]), 64'(1));
    wr("R6", 1, 2, 8'h01); tick("R6");
    check("R6", "drain dma", 64'(dmaDrain[1]), 64'(1));

    // R8: software clear ignored in DMA mode, auto-clear on empty
    wr("R8", 1, 0, 8'h08);
    rd("R8", 1, 0, 8'h08);
    emp[1] = 1'b1; tick("R8");
    rd("R8", 1, 0, 8'h00);

    // R7 and R9: fill routing and auto-clear on full
    full[1] = 1'b0; tick("R7"); tick("R7");
    check("R7", "fill irq", 64'(irqOut[1*8+4]), 64'(1));
    wr("R7", 1, 2, 8'h02); tick("R7");
    check("R7", "fill dma", 64'(dmaFill[1]), 64'(1));
    wr("R9", 1, 0, 8'h10);
    rd("R9", 1, 0, 8'h10);
    full[1] = 1'b1; tick("R9");
    rd("R9", 1, 0, 8'h00);

    // R10: combined error line from another queue
    wr("R10", 5, 1, 8'h80);
    evt[5] = 8'h80; tick("R10"); evt = '0; tick("R10");
    check("R10", "errIrq", 64'(errIrq), 64'(1));
    wr("R10", 5, 0, 8'h80); tick("R10");
    check("R10", "errIrq cleared", 64'(errIrq), 64'(0));

    // Mixed random traffic, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      for (int q = 0; q < NQ; q++) begin
        for (int b = 0; b < 8; b++) evt[q][b] = ($urandom % 16) == 0;
        if ($urandom % 8 == 0) emp[q] = ~emp[q];
        if ($urandom % 8 == 0) full[q] = ~full[q];
      end
      regWe = ($urandom % 4) == 0;
      regAddr = {3'($urandom % NQ), 2'($urandom % 3)};
      regWdata = 8'($urandom);
      tick("R3");
    end
    regWe = 1'b0; evt = '0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule